// File: doc/BRIEF.md
# AGC Gain-State Dwell Controller

This block decides when a receiver front end runs in its high-gain or its reduced-gain state. It never sees the signal level itself. It sees two comparator flags that an analog stage derives from the level. One flag means the level is above an upper switching threshold. The other means the level is below a lower release threshold. The gap between the two thresholds gives the loop its hysteresis. Moving to low gain is immediate. Moving back to high gain waits until the level has stayed below the lower threshold for a dwell of 2^K reference-clock cycles.

A two-bit mode code selects the dwell exponent K. Code 00 turns the function off, and the front end then stays in high gain. All timing advances only on cycles that carry the reference-clock enable. Each gain change produces a one-cycle event pulse. Downstream peak trackers use this pulse to re-acquire their levels after the step in gain. The exponent is captured when a dwell starts, so a mode change made while a dwell is running has no effect until the next dwell begins.

Top module: `agc_dwell_ctrl`

## Requirements
- R1: After reset the block is in high gain (gain_low = 0), gain_evt is 0 and the dwell count is zero, so the first dwell after reset runs its full length.
- R2: Mode code 2'b01 selects exponent K_SHORT (default 11), 2'b10 selects K_MID (default 14) and 2'b11 selects K_LONG (default 20). A dwell lasts 2^K enabled cycles.
- R3: Mode code 2'b00 disables the function. At the next clock edge gain_low is 0, whatever clk_en is. While the code is 00, gain_low stays 0, above_hi is ignored and gain_evt is never raised.
- R4: In high gain, with a non-zero mode, an enabled cycle with above_hi = 1 sets gain_low = 1 at that clock edge.
- R5: In low gain, the block returns to high gain only at the edge that closes the 2^K-th consecutive enabled cycle with below_lo = 1. With below_lo = 0 (including when above_hi = 1, or when both flags are low) the block stays in low gain.
- R6: An enabled cycle in low gain with below_lo = 0 clears the dwell count. The next run of below_lo needs a full 2^K enabled cycles.
- R7: The exponent is taken from the mode code in the first enabled cycle of a dwell (count zero). Mode changes later in the same dwell do not change its length.
- R8: With clk_en = 0 and a non-zero mode, gain_low does not change, the dwell count does not advance, and gain_evt stays 0.
- R9: gain_evt is 1 for exactly the one clock cycle in which gain_low first shows a new value produced by R4 or R5. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Reference-clock enable; timing advances only when high |
| above_hi | input | 1 | Level is above the upper (switch-down) threshold |
| below_lo | input | 1 | Level is below the lower (release) threshold |
| mode | input | 2 | 00 off; 01, 10, 11 select a dwell exponent |
| gain_low | output | 1 | 1 requests the reduced-gain (attenuated) state |
| gain_evt | output | 1 | One-cycle pulse on every gain-state change |

## Verification
The dwell count is not visible at the ports, so a wrong count shows up only as a release on the wrong edge. The bench therefore checks gain_low on the edge before the expected release and on the release edge itself. It does this for a fresh dwell, for a dwell restarted after an interruption, for a dwell whose mode changes partway through, and for a dwell stretched by enable gaps. An off-by-one in the count, or a count that was not cleared, moves the release by at least one edge. A wrongly latched exponent moves it by a whole power of two. A wrong state register shows up one edge after an attack or after disable, as a wrong gain_low or a missing or extra gain_evt.

// File: rtl/agc_dwell_pkg.sv
package agc_dwell_pkg;

   // Mode code; the bit pattern is decoded by the dwell timer.
   typedef enum logic [1:0] {
      AGC_OFF   = 2'b00,
      AGC_DW_S  = 2'b01,
      AGC_DW_M  = 2'b10,
      AGC_DW_L  = 2'b11
   } agc_mode_e;

   typedef enum logic {
      GAIN_HIGH = 1'b0,
      GAIN_LOW  = 1'b1
   } gain_e;

endpackage

// File: rtl/agc_dwell_timer.sv
module agc_dwell_timer #(
   parameter int K_SHORT = 11,
   parameter int K_MID   = 14,
   parameter int K_LONG  = 20,
   parameter int CNT_W   = 21
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       run,
   input  logic [1:0] mode,
   output logic       expire
);
   import agc_dwell_pkg::*;

   localparam int KW = $clog2(K_LONG + 1);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [KW-1:0]    k_lat_q;
   logic [KW-1:0]    k_live;
   logic [KW-1:0]    k_use;
   logic [CNT_W-1:0] last;
   logic             at_start;

   always_comb begin
      unique case (agc_mode_e'(mode))
         AGC_DW_M: k_live = KW'(K_MID);
         AGC_DW_L: k_live = KW'(K_LONG);
         default:  k_live = KW'(K_SHORT);
      endcase
   end

   assign at_start = (cnt_q == '0);
   assign k_use    = at_start ? k_live : k_lat_q;
   assign last     = (ONE << k_use) - ONE;
   assign expire   = tick & run & (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         k_lat_q <= KW'(K_SHORT);
      end else if (tick) begin
         if (!run || expire) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + ONE;
         end
         if (run && at_start) begin
            k_lat_q <= k_live;
         end
      end
   end

endmodule

// File: rtl/agc_gain_fsm.sv
module agc_gain_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic active,
   input  logic above_hi,
   input  logic expire,
   output logic gain_low,
   output logic gain_evt
);
   import agc_dwell_pkg::*;

   gain_e st_q;
   logic  evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= GAIN_HIGH;
         evt_q <= 1'b0;
      end else begin
         evt_q <= 1'b0;
         if (!active) begin
            st_q <= GAIN_HIGH;
         end else if (tick) begin
            if (st_q == GAIN_HIGH && above_hi) begin
               st_q  <= GAIN_LOW;
               evt_q <= 1'b1;
            end else if (st_q == GAIN_LOW && expire) begin
               st_q  <= GAIN_HIGH;
               evt_q <= 1'b1;
            end
         end
      end
   end

   assign gain_low = (st_q == GAIN_LOW);
   assign gain_evt = evt_q;

endmodule

// File: rtl/agc_dwell_ctrl.sv
module agc_dwell_ctrl #(
   parameter int K_SHORT = 11,
   parameter int K_MID   = 14,
   parameter int K_LONG  = 20,
   parameter int CNT_W   = 21
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clk_en,
   input  logic       above_hi,
   input  logic       below_lo,
   input  logic [1:0] mode,
   output logic       gain_low,
   output logic       gain_evt
);
   import agc_dwell_pkg::*;

   localparam int K_MAX = (K_LONG > K_MID) ? ((K_LONG > K_SHORT) ? K_LONG : K_SHORT)
                                           : ((K_MID > K_SHORT) ? K_MID : K_SHORT);

   generate
      if (K_SHORT < 1 || K_MID < 1 || K_LONG < 1) begin : g_bad_k
         $error("dwell exponents must be at least 1");
      end
      if (K_MAX >= CNT_W) begin : g_bad_w
         $error("CNT_W must exceed the largest dwell exponent");
      end
      if (K_LONG < K_MAX) begin : g_bad_order
         $error("K_LONG must be the largest dwell exponent");
      end
   endgenerate

   logic active;
   logic run;
   logic expire;

   assign active = (agc_mode_e'(mode) != AGC_OFF);
   assign run    = gain_low & below_lo & active;

   agc_dwell_timer #(
      .K_SHORT (K_SHORT),
      .K_MID   (K_MID),
      .K_LONG  (K_LONG),
      .CNT_W   (CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (clk_en),
      .run    (run),
      .mode   (mode),
      .expire (expire)
   );

   agc_gain_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (clk_en),
      .active   (active),
      .above_hi (above_hi),
      .expire   (expire),
      .gain_low (gain_low),
      .gain_evt (gain_evt)
   );

endmodule

// File: rtl/agc_dwell_chk.sv
module agc_dwell_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       clk_en,
   input logic       above_hi,
   input logic       below_lo,
   input logic [1:0] mode,
   input logic       gain_low,
   input logic       gain_evt
);

   a_r3_off_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> (!gain_low && !gain_evt));

   a_r4_attack: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && mode != 2'b00 && !gain_low && above_hi) |=> (gain_low && gain_evt));

   a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'b00 && gain_low && !(clk_en && below_lo)) |=> gain_low);

   a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en && mode != 2'b00) |=> (gain_low == $past(gain_low) && !gain_evt));

   a_r9_evt_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
      gain_evt |-> (gain_low != $past(gain_low)));

   a_r9_change_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_low != $past(gain_low) && $past(mode) != 2'b00) |-> gain_evt);

endmodule

bind agc_dwell_ctrl agc_dwell_chk u_chk (.*);

// File: tb/tb_agc_dwell_ctrl.sv
module tb_agc_dwell_ctrl;

   localparam int CLK_P   = 10;
   localparam int KS      = 3;
   localparam int KM      = 4;
   localparam int KL      = 5;
   localparam int WD_MAX  = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_en = 1'b0;
   logic       above_hi = 1'b0;
   logic       below_lo = 1'b0;
   logic [1:0] mode = 2'b01;
   logic       gain_low;
   logic       gain_evt;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   agc_dwell_ctrl #(.K_SHORT(KS), .K_MID(KM), .K_LONG(KL), .CNT_W(6)) dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .above_hi(above_hi),
      .below_lo(below_lo), .mode(mode), .gain_low(gain_low), .gain_evt(gain_evt)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_MAX) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog expired after %0d cycles (expected completion)", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic act, input logic exp_v);
      total = total + 1;
      if (act !== exp_v) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%b expected=%b at cycle %0d", req, act, exp_v, cyc);
      end
   endtask

   task automatic go_low(input logic [1:0] m);
      mode = m;
      clk_en = 1'b1;
      below_lo = 1'b0;
      above_hi = 1'b1;
      step();
      above_hi = 1'b0;
      chk("R4 attack gain", gain_low, 1'b1);
      chk("R9 attack event", gain_evt, 1'b1);
   endtask

   // Holds below_lo for a full dwell of 2^k edges and checks the release edge.
   task automatic run_dwell(input string req, input int k);
      int lim = 1 << k;
      below_lo = 1'b1;
      for (int n = 1; n <= lim; n++) begin
         step();
         if (n == lim - 1) chk({req, " still low before dwell end"}, gain_low, 1'b1);
         if (n == lim) begin
            chk({req, " released at dwell end"}, gain_low, 1'b0);
            chk({req, " R9 release event"}, gain_evt, 1'b1);
         end
      end
      below_lo = 1'b0;
      step();
      chk({req, " R9 event lasts one cycle"}, gain_evt, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 reset gain", gain_low, 1'b0);
      chk("R1 reset event", gain_evt, 1'b0);
   endtask

   task automatic t_modes();
      go_low(2'b01); run_dwell("R2 mode01", KS);
      go_low(2'b10); run_dwell("R2 mode10", KM);
      go_low(2'b11); run_dwell("R2 mode11", KL);
   endtask

   task automatic t_hysteresis();
      go_low(2'b01);
      above_hi = 1'b1;
      for (int i = 0; i < 12; i++) step();
      chk("R5 above_hi keeps low gain", gain_low, 1'b1);
      chk("R5 no event while held", gain_evt, 1'b0);
      above_hi = 1'b0;
      for (int i = 0; i < 12; i++) step();
      chk("R5 between thresholds keeps low gain", gain_low, 1'b1);
      run_dwell("R5 release", KS);
   endtask

   task automatic t_interrupt();
      go_low(2'b01);
      below_lo = 1'b1;
      for (int i = 0; i < (1 << KS) - 1; i++) step();
      below_lo = 1'b0;
      step();
      chk("R6 break keeps low gain", gain_low, 1'b1);
      run_dwell("R6 restart full dwell", KS);
   endtask

   task automatic t_mode_change();
      go_low(2'b01);
      below_lo = 1'b1;
      step();
      step();
      mode = 2'b11;
      for (int n = 3; n <= (1 << KS); n++) begin
         step();
         if (n == (1 << KS) - 1) chk("R7 still low before latched end", gain_low, 1'b1);
      end
      chk("R7 latched exponent used", gain_low, 1'b0);
      below_lo = 1'b0;
      step();
      run_dwell_wrap();
   endtask

   task automatic run_dwell_wrap();
      go_low(2'b11);
      run_dwell("R7 new mode at next dwell", KL);
   endtask

   task automatic t_enable();
      mode = 2'b01;
      clk_en = 1'b0;
      above_hi = 1'b1;
      for (int i = 0; i < 4; i++) step();
      chk("R8 disabled clock blocks attack", gain_low, 1'b0);
      chk("R8 no event", gain_evt, 1'b0);
      above_hi = 1'b0;
      go_low(2'b01);
      below_lo = 1'b1;
      for (int i = 0; i < (1 << KS) - 1; i++) step();
      clk_en = 1'b0;
      for (int i = 0; i < 10; i++) step();
      chk("R8 count frozen while disabled", gain_low, 1'b1);
      clk_en = 1'b1;
      step();
      chk("R8 resumes and ends dwell", gain_low, 1'b0);
      chk("R9 event after resume", gain_evt, 1'b1);
      below_lo = 1'b0;
      step();
   endtask

   task automatic t_disable();
      go_low(2'b10);
      mode = 2'b00;
      clk_en = 1'b0;
      step();
      chk("R3 off forces high gain", gain_low, 1'b0);
      chk("R3 forced change has no event", gain_evt, 1'b0);
      clk_en = 1'b1;
      above_hi = 1'b1;
      for (int i = 0; i < 5; i++) begin
         step();
         if (gain_evt) chk("R3 no event while off", gain_evt, 1'b0);
      end
      chk("R3 above_hi ignored while off", gain_low, 1'b0);
      above_hi = 1'b0;
      step();
   endtask

   initial begin
      #(CLK_P * 3 + 2);
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_modes();
      t_hysteresis();
      t_interrupt();
      t_mode_change();
      t_enable();
      t_disable();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule